// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block combines four event sources into one active-low interrupt request for a Z80-style processor. The sources are a raster-line event and three DMA channel events. During the processor's interrupt acknowledge cycle, the block places a mode-2 vector byte on the data bus. Each source keeps a pending flag. A fixed priority resolver picks one flag when the acknowledge arrives, and the vector byte names the chosen source in bits 2:1.

Software configures the block through three register slots. A vector base register supplies vector bits 7:3. A control register holds an auto-clear-off bit. A status slot reports the pending flags when read and clears DMA flags when written with ones.

When the raster source wins an acknowledge, the block sends a one-cycle pulse to the line counter. That pulse clears bit 5 of the counter. A DMA acknowledge never produces the pulse. The reset input is asynchronous on assertion and synchronous on release, through an internal two-stage synchronizer.

Top module: `vpic_top`

## Requirements
- R1: After reset, the vector register reads 0x01, the control register reads 0x00 and the status reads 0x00. int_n is high, vec_oe is low and line_clr5 is low.
- R2: A one-cycle request pulse on raster_req or dma_req[k] sets that source's pending flag at the next clock edge. int_n is low in every cycle in which any flag is pending.
- R3: An acknowledge is recognised while m1_n and iorq_n are both low. vec_oe is high for that whole time, and vec_out = {ivr[7:3], code, 0}. The source codes are DMA2 = 00, DMA1 = 01, DMA0 = 10 and raster = 11.
- R4: The winner is chosen from the flags pending in the first acknowledge cycle, in the order raster > DMA2 > DMA1 > DMA0. The order in which the requests arrived has no effect.
- R5: With auto-clear on (control bit 0 = 0), an acknowledge clears only the winner's flag, at the end of its first cycle. Any other pending flag keeps int_n low.
- R6: With auto-clear off (control bit 0 = 1), a winning DMA flag survives the acknowledge. A winning raster flag is still cleared.
- R7: Writing to the status slot (reg_sel = 2) clears the DMA2, DMA1 and DMA0 flags whose bits 6, 5 and 4 are written as 1. Bits written as 0, and bit 7, change nothing.
- R8: line_clr5 is high only in the first acknowledge cycle, and only when the raster source wins.
- R9: A request that arrives in the same cycle as a clear of the same flag, whether from an acknowledge or from software, leaves the flag set.
- R10: A status read (reg_sel = 2) returns raster in bit 7 and DMA2, DMA1 and DMA0 in bits 6, 5 and 4; bits 3:0 read 0. reg_sel = 0 reads the vector register and reg_sel = 1 reads the control register.
- R11: vec_out holds the value chosen in the first acknowledge cycle for as long as the acknowledge lasts, even though the winner's flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot: 0 vector, 1 control, 2 status/clear |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_sel (combinational) |
| raster_req | input | 1 | Raster event pulse |
| dma_req | input | 3 | DMA channel event pulses, bit k is channel k |
| m1_n | input | 1 | Processor M1, active low |
| iorq_n | input | 1 | Processor IORQ, active low |
| int_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector byte drive enable |
| vec_out | output | 8 | Vector byte, zero outside acknowledge |
| line_clr5 | output | 1 | Pulse that clears bit 5 of the line counter |

## Verification
A request sets its flag at the clock edge that samples it. int_n therefore falls in the cycle after the pulse, and the bench checks it then. vec_out, vec_oe and line_clr5 are combinational from m1_n and iorq_n, so the bench checks them within the first acknowledge cycle, before the next edge. It then checks them again in the second cycle to confirm the latched vector. The acknowledge clears flags at the edge that ends the first cycle, and the bench reads the status only after the acknowledge is released. Register writes take effect at the edge that samples reg_wr, and reads are combinational, so every read is made one cycle after the write.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NSRC   = 4;
  localparam int CODE_W = 2;
  localparam int DATA_W = 8;

  typedef logic [CODE_W-1:0] src_code_t;

  // flag index equals the vector code of the source
  localparam src_code_t CODE_DMA2   = 2'd0;
  localparam src_code_t CODE_DMA1   = 2'd1;
  localparam src_code_t CODE_DMA0   = 2'd2;
  localparam src_code_t CODE_RASTER = 2'd3;

  typedef enum logic [1:0] {
    SEL_IVR  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ivr_o,
  output logic              acoff_o
);
  logic [DATA_W-1:0] ivr_q, ivr_d;
  logic              acoff_q, acoff_d;
  logic              ivr_en, ctrl_en;

  always_comb begin
    ivr_en  = wr_i && (sel_i == SEL_IVR);
    ctrl_en = wr_i && (sel_i == SEL_CTRL);
    ivr_d   = ivr_en  ? wdata_i    : ivr_q;
    acoff_d = ctrl_en ? wdata_i[0] : acoff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivr_q   <= {{(DATA_W-1){1'b0}}, 1'b1};
      acoff_q <= 1'b0;
    end else begin
      ivr_q   <= ivr_d;
      acoff_q <= acoff_d;
    end
  end

  assign ivr_o   = ivr_q;
  assign acoff_o = acoff_q;
endmodule

// File: rtl/vpic_flags.sv
module vpic_flags
  import vpic_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q, flag_d;
    // a new event outranks a clear in the same cycle
    always_comb flag_d = set_i[k] | (flag_q & ~clr_i[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end
    assign pend_o[k] = flag_q;
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
  import vpic_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic            valid_o,
  output src_code_t       code_o
);
  always_comb begin
    valid_o = |pend_i;
    if      (pend_i[CODE_RASTER]) code_o = CODE_RASTER;
    else if (pend_i[CODE_DMA2])   code_o = CODE_DMA2;
    else if (pend_i[CODE_DMA1])   code_o = CODE_DMA1;
    else if (pend_i[CODE_DMA0])   code_o = CODE_DMA0;
    else                          code_o = CODE_DMA2;
  end
endmodule

// File: rtl/vpic_ack.sv
module vpic_ack
  import vpic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      m1_n,
  input  logic      iorq_n,
  input  src_code_t code_i,
  output logic      ack_o,
  output logic      start_o,
  output src_code_t code_o
);
  logic      ack_q, ack_d;
  src_code_t code_q, code_d;
  logic      start;

  always_comb begin
    ack_d  = !m1_n && !iorq_n;
    start  = ack_d && !ack_q;
    code_d = start ? code_i : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      code_q <= CODE_DMA2;
    end else begin
      ack_q  <= ack_d;
      code_q <= code_d;
    end
  end

  assign ack_o   = ack_d;
  assign start_o = start;
  assign code_o  = start ? code_i : code_q;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic        raster_req,
  input  logic [2:0]  dma_req,
  input  logic        m1_n,
  input  logic        iorq_n,
  output logic        int_n,
  output logic        vec_oe,
  output logic [7:0]  vec_out,
  output logic        line_clr5
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] ivr_q;
  logic              acoff_q;
  logic [NSRC-1:0]   pend_q, set_v, clr_v, sw_clr, ack_clr;
  logic              win_valid, ack, ack_start;
  src_code_t         win_code, vec_code;

  vpic_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_i(reg_wr), .sel_i(reg_sel),
    .wdata_i(wr_data), .ivr_o(ivr_q), .acoff_o(acoff_q)
  );

  vpic_arb u_arb (.pend_i(pend_q), .valid_o(win_valid), .code_o(win_code));

  vpic_ack u_ack (
    .clk(clk), .rst_n(rst_core_n), .m1_n(m1_n), .iorq_n(iorq_n),
    .code_i(win_code), .ack_o(ack), .start_o(ack_start), .code_o(vec_code)
  );

  always_comb begin
    set_v = '0;
    set_v[CODE_RASTER] = raster_req;
    set_v[CODE_DMA2]   = dma_req[2];
    set_v[CODE_DMA1]   = dma_req[1];
    set_v[CODE_DMA0]   = dma_req[0];

    sw_clr = '0;
    if (reg_wr && reg_sel == SEL_STAT) begin
      sw_clr[CODE_DMA2] = wr_data[6];
      sw_clr[CODE_DMA1] = wr_data[5];
      sw_clr[CODE_DMA0] = wr_data[4];
    end

    ack_clr = '0;
    if (ack_start && win_valid && (win_code == CODE_RASTER || !acoff_q))
      ack_clr[win_code] = 1'b1;

    clr_v = sw_clr | ack_clr;
  end

  vpic_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend_q)
  );

  always_comb begin
    case (reg_sel)
      SEL_IVR:  rd_data = ivr_q;
      SEL_CTRL: rd_data = {7'd0, acoff_q};
      SEL_STAT: rd_data = {pend_q[CODE_RASTER], pend_q[CODE_DMA2],
                           pend_q[CODE_DMA1], pend_q[CODE_DMA0], 4'd0};
      default:  rd_data = 8'd0;
    endcase
    int_n     = ~|pend_q;
    vec_oe    = ack;
    vec_out   = ack ? {ivr_q[7:3], vec_code, 1'b0} : 8'd0;
    line_clr5 = ack_start && win_valid && (win_code == CODE_RASTER);
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_n,
  input logic       raster_req,
  input logic       m1_n,
  input logic       iorq_n,
  input logic [7:0] vec_out,
  input logic       line_clr5,
  input logic [3:0] pend,
  input logic       acoff
);
  logic ack;
  assign ack = !m1_n && !iorq_n;

  AST_REQ_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    raster_req |=> !int_n); // R2

  AST_CLR5_ONLY_RASTER: assert property (@(posedge clk) disable iff (!rst_n)
    line_clr5 |-> (ack && vec_out[2:1] == 2'b11)); // R8

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |-> $stable(vec_out)); // R11

  AST_RASTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(ack) && pend[3]) |-> vec_out[2:1] == 2'b11); // R4

  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(ack) && pend[3]) |=>
      ((pend[2:0] & $past(pend[2:0])) == $past(pend[2:0]))); // R5

  AST_ACOFF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(ack) && acoff && !pend[3] && |pend[2:0]) |=>
      ((pend & $past(pend)) == $past(pend))); // R6
endmodule

bind vpic_top vpic_chk chk_i (
  .clk(clk), .rst_n(rst_core_n), .int_n(int_n), .raster_req(raster_req),
  .m1_n(m1_n), .iorq_n(iorq_n), .vec_out(vec_out), .line_clr5(line_clr5),
  .pend(pend_q), .acoff(acoff_q)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, reg_wr, raster_req, m1_n, iorq_n;
  logic [1:0] reg_sel;
  logic [7:0] wr_data, rd_data, vec_out;
  logic [2:0] dma_req;
  logic       int_n, vec_oe, line_clr5;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  vpic_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .raster_req(raster_req),
    .dma_req(dma_req), .m1_n(m1_n), .iorq_n(iorq_n), .int_n(int_n),
    .vec_oe(vec_oe), .vec_out(vec_out), .line_clr5(line_clr5)
  );

  // {req raster,d2,d1,d0 | acoff | code | clr5 | status raster,d2,d1,d0}
  localparam logic [11:0] VECS [10] = '{
    {4'b1000, 1'b0, 2'b11, 1'b1, 4'b0000},
    {4'b0100, 1'b0, 2'b00, 1'b0, 4'b0000},
    {4'b0010, 1'b0, 2'b01, 1'b0, 4'b0000},
    {4'b0001, 1'b0, 2'b10, 1'b0, 4'b0000},
    {4'b1111, 1'b0, 2'b11, 1'b1, 4'b0111},
    {4'b0111, 1'b0, 2'b00, 1'b0, 4'b0011},
    {4'b0011, 1'b0, 2'b01, 1'b0, 4'b0001},
    {4'b0100, 1'b1, 2'b00, 1'b0, 4'b0100},
    {4'b1001, 1'b1, 2'b11, 1'b1, 4'b0001},
    {4'b0101, 1'b1, 2'b00, 1'b0, 4'b0101}
  };

  task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; wr_data = 8'd0;
    raster_req = 1'b0; dma_req = 3'd0; m1_n = 1'b1; iorq_n = 1'b1;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc(); cyc(); cyc();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; wr_data = d;
    cyc();
    reg_wr = 1'b0; reg_sel = 2'd3; wr_data = 8'd0;
  endtask

  task automatic pulse(input logic [3:0] req);
    raster_req = req[3]; dma_req = req[2:0];
    cyc();
    raster_req = 1'b0; dma_req = 3'd0;
  endtask

  task automatic read_chk(input logic [1:0] sel, input logic [7:0] exp, input string req);
    reg_sel = sel;
    #1;
    check8(rd_data, exp, req);
    reg_sel = 2'd3;
  endtask

  // two-cycle acknowledge; checks vector and pulse in both cycles
  task automatic ack_chk(input logic [7:0] exp_vec, input logic exp_clr5, input string req);
    m1_n = 1'b0; iorq_n = 1'b0;
    #1;
    check8(vec_out, exp_vec, req);
    check8({7'd0, vec_oe}, 8'd1, "R3 vec_oe");
    check8({7'd0, line_clr5}, {7'd0, exp_clr5}, "R8 clr5 first cycle");
    cyc();
    check8(vec_out, exp_vec, "R11 held vector");
    check8({7'd0, line_clr5}, 8'd0, "R8 clr5 second cycle");
    m1_n = 1'b1; iorq_n = 1'b1;
    cyc();
    check8({7'd0, vec_oe}, 8'd0, "R3 vec_oe released");
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, R10 read slots
    do_reset();
    read_chk(2'd0, 8'h01, "R1 ivr reset");
    read_chk(2'd1, 8'h00, "R1 ctrl reset");
    read_chk(2'd2, 8'h00, "R1 R10 status reset");
    check8({int_n, vec_oe, line_clr5, 5'd0}, 8'h80, "R1 outputs reset");

    // table walk: R2 R3 R4 R5 R6 R8
    foreach (VECS[i]) begin
      logic [11:0] v;
      v = VECS[i];
      do_reset();
      wr(2'd0, 8'hA9);
      wr(2'd1, {7'd0, v[7]});
      pulse(v[11:8]);
      check8({7'd0, int_n}, 8'd0, "R2 int asserted");
      ack_chk({5'b10101, v[6:5], 1'b0}, v[4], "R3 R4 vector");
      read_chk(2'd2, {v[3:0], 4'd0}, "R5 R6 R10 status after ack");
      check8({7'd0, int_n}, {7'd0, ~|v[3:0]}, "R5 int after ack");
    end

    // R4 arrival order ignored
    do_reset();
    wr(2'd0, 8'hA9);
    pulse(4'b0001);
    cyc(); cyc(); cyc();
    pulse(4'b1000);
    ack_chk(8'hAE, 1'b1, "R4 late raster wins");
    ack_chk(8'hAC, 1'b0, "R4 DMA0 second");
    check8({7'd0, int_n}, 8'd1, "R5 int released");

    // R7 software clear with auto-clear off
    do_reset();
    wr(2'd1, 8'h01);
    pulse(4'b0101);
    wr(2'd2, 8'h40);
    read_chk(2'd2, 8'h10, "R7 clear DMA2");
    wr(2'd2, 8'h8F);
    read_chk(2'd2, 8'h10, "R7 zeros ignored");
    wr(2'd2, 8'h10);
    read_chk(2'd2, 8'h00, "R7 clear DMA0");
    check8({7'd0, int_n}, 8'd1, "R7 int released");

    // R9 set wins over software clear
    pulse(4'b0010);
    dma_req = 3'b010;
    wr(2'd2, 8'h20);
    dma_req = 3'd0;
    read_chk(2'd2, 8'h20, "R9 set beats sw clear");

    // R9 set wins over ack clear
    pulse(4'b1000);
    raster_req = 1'b1;
    m1_n = 1'b0; iorq_n = 1'b0;
    cyc();
    raster_req = 1'b0;
    m1_n = 1'b1; iorq_n = 1'b1;
    cyc();
    read_chk(2'd2, 8'hA0, "R9 set beats ack clear");

    // R3 new vector base
    wr(2'd0, 8'h57);
    read_chk(2'd0, 8'h57, "R10 ivr readback");
    ack_chk(8'h56, 1'b1, "R3 new base");
    read_chk(2'd2, 8'h20, "R6 DMA1 kept, raster cleared");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule